// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers one-cycle event pulses from a set of peripheral sources, such as a finished disk block, an emptied audio buffer or the start of vertical blanking. Each pulse is held in its own bit of a pending register. A second register holds one enable bit per source and a master enable. Every source is tied at build time to a priority level from 1 to 7. The block reports the highest level among the enabled pending sources to a processor on a registered 3-bit output, together with the index of the source that won.

The processor side supplies its current mask level and can acknowledge the level it is servicing. An acknowledge retires the winning source at that level. Software reaches both registers through a small write/read port. The top bit of the write data chooses between setting and clearing the bits that are written as ones. Level 7 cannot be masked. A request that is masked, or that loses arbitration, stays pending until it can be shown.

Top module: `intc_prio`

## Requirements
- R1: A one-cycle pulse on `evt_i[i]` sets pending bit i. The bit can be read back at bit i of `bus_rdata` with `bus_sel`=0, and it stays set until cleared.
- R2: A write with `bus_wdata[15]`=1 sets every selected bit whose data bit is 1. With `bus_wdata[15]`=0 it clears those bits. Other bits keep their value. `bus_sel`=0 selects the pending register. `bus_sel`=1 selects the enable register, whose bits [N-1:0] are the per-source enables and whose bit 14 is the master enable.
- R3: If an event pulse arrives in the same cycle as a software clear or an acknowledge of the same bit, the bit ends up set.
- R4: A pending source whose enable bit is 0 stays latched but is never reported on `irq_lvl`.
- R5: For levels 1 to 6, `irq_lvl` shows a level only when that level is strictly greater than `cpu_mask`. Otherwise it shows 0.
- R6: An enabled pending level-7 source is reported as level 7, whatever the value of `cpu_mask` and of the master enable.
- R7: When the master enable is 0, no level from 1 to 6 is reported.
- R8: When several reportable sources are pending, the highest level is reported. With the default mapping, source 4 (vertical blank, level 3) beats source 1 (disk block, level 1).
- R9: A request that is held back by the mask stays pending. It is reported once `cpu_mask` drops below its level.
- R10: After reset, `irq_lvl`, `irq_src` and both registers are 0. `irq_lvl` and `irq_src` are registered: a change in pending state appears one clock after the edge that latched it.
- R11: Among reportable sources at the winning level, the lowest index appears on `irq_src`.
- R12: A `cpu_ack` with level L clears the pending bit of the lowest-index reportable source at level L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NSRC | One-cycle event pulses, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 selects the pending register, 1 selects the enable register |
| bus_wdata | input | 16 | Write data; bit 15 chooses set (1) or clear (0) |
| bus_rdata | output | 16 | Contents of the selected register |
| cpu_mask | input | 3 | Current processor mask level |
| cpu_ack | input | 1 | Acknowledge strobe |
| cpu_ack_lvl | input | 3 | Level being acknowledged |
| irq_lvl | output | 3 | Registered level presented to the processor |
| irq_src | output | IDX_W | Registered index of the winning source |

## Verification
The cases that are hardest to reach from the ports are the collisions, where an event pulse lands in the same cycle as a software clear or an acknowledge of the same bit. The bench produces them by driving the pulse and the bus write, or the acknowledge, on the same falling edge, so that both take effect on one rising edge. It then reads the pending register back.

The non-maskable path is reached in a similar way. The bench first turns off the master enable and raises the mask to 7, and only then pulses the level-7 source.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int DATA_W     = 16;
    localparam int CTRL_BIT   = 15;
    localparam int MASTER_BIT = 14;
    localparam int LVL_W      = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t NO_IRQ   = 3'd0;
    localparam lvl_t NMI_LVL  = 3'd7;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt,
    input  logic              wr,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   ack_clr,
    output logic [NSRC-1:0]   req,
    output logic [NSRC-1:0]   en,
    output logic              master,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [NSRC-1:0] req;
        logic [NSRC-1:0] en;
        logic            master;
    } regs_t;

    regs_t st_d, st_q;
    logic  unused_wbits;

    assign unused_wbits = ^wdata[MASTER_BIT-1:NSRC];

    always_comb begin
        st_d = st_q;
        if (wr && !sel) begin
            if (wdata[CTRL_BIT]) st_d.req = st_q.req | wdata[NSRC-1:0];
            else                 st_d.req = st_q.req & ~wdata[NSRC-1:0];
        end
        if (wr && sel) begin
            if (wdata[CTRL_BIT]) begin
                st_d.en     = st_q.en | wdata[NSRC-1:0];
                st_d.master = st_q.master | wdata[MASTER_BIT];
            end else begin
                st_d.en     = st_q.en & ~wdata[NSRC-1:0];
                st_d.master = st_q.master & ~wdata[MASTER_BIT];
            end
        end
        st_d.req = (st_d.req & ~ack_clr) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata[NSRC-1:0]   = st_q.en;
            rdata[MASTER_BIT] = st_q.master;
        end else begin
            rdata[NSRC-1:0]   = st_q.req;
        end
    end

    assign req    = st_q.req;
    assign en     = st_q.en;
    assign master = st_q.master;
endmodule

// File: rtl/intc_arb.sv
module intc_arb
    import intc_pkg::*;
#(
    parameter int                   NSRC      = 8,
    parameter logic [NSRC*LVL_W-1:0] SRC_LEVEL = '0,
    localparam int                  IDX_W     = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  req,
    input  logic [NSRC-1:0]  en,
    input  logic             master,
    input  lvl_t             mask,
    input  logic             ack,
    input  lvl_t             ack_lvl,
    output lvl_t             lvl_d,
    output logic [IDX_W-1:0] src_d,
    output logic [NSRC-1:0]  ack_clr
);
    lvl_t            src_lvl [NSRC];
    logic [NSRC-1:0] active;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign src_lvl[g] = SRC_LEVEL[g*LVL_W +: LVL_W];
        assign active[g]  = req[g] & en[g] & (master | (src_lvl[g] == NMI_LVL));
    end

    lvl_t             best;
    logic [IDX_W-1:0] best_idx;
    logic             found;
    logic             ack_found;

    always_comb begin
        best = NO_IRQ;
        for (int i = 0; i < NSRC; i++) begin
            if (active[i] && src_lvl[i] > best) best = src_lvl[i];
        end
        best_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (!found && active[i] && src_lvl[i] == best) begin
                best_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
        if (best == NMI_LVL || best > mask) begin
            lvl_d = best;
            src_d = best_idx;
        end else begin
            lvl_d = NO_IRQ;
            src_d = '0;
        end
    end

    always_comb begin
        ack_clr   = '0;
        ack_found = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (ack && !ack_found && active[i] && src_lvl[i] == ack_lvl) begin
                ack_clr[i] = 1'b1;
                ack_found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intc_prio.sv
module intc_prio
    import intc_pkg::*;
#(
    parameter int                    NSRC      = 8,
    parameter logic [NSRC*LVL_W-1:0] SRC_LEVEL = {3'd7, 3'd4, 3'd3, 3'd3, 3'd2, 3'd1, 3'd1, 3'd1},
    localparam int                   IDX_W     = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [2:0]        cpu_mask,
    input  logic              cpu_ack,
    input  logic [2:0]        cpu_ack_lvl,
    output logic [2:0]        irq_lvl,
    output logic [IDX_W-1:0]  irq_src
);
    typedef struct packed {
        lvl_t             lvl;
        logic [IDX_W-1:0] src;
    } out_t;

    logic [NSRC-1:0]  req_w, en_w, ack_clr_w;
    logic             master_w;
    lvl_t             lvl_w;
    logic [IDX_W-1:0] src_w;
    out_t             out_d, out_q;

    intc_regs #(.NSRC(NSRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_i),
        .wr      (bus_wr),
        .sel     (bus_sel),
        .wdata   (bus_wdata),
        .ack_clr (ack_clr_w),
        .req     (req_w),
        .en      (en_w),
        .master  (master_w),
        .rdata   (bus_rdata)
    );

    intc_arb #(.NSRC(NSRC), .SRC_LEVEL(SRC_LEVEL)) u_arb (
        .req     (req_w),
        .en      (en_w),
        .master  (master_w),
        .mask    (cpu_mask),
        .ack     (cpu_ack),
        .ack_lvl (cpu_ack_lvl),
        .lvl_d   (lvl_w),
        .src_d   (src_w),
        .ack_clr (ack_clr_w)
    );

    always_comb begin
        out_d     = out_q;
        out_d.lvl = lvl_w;
        out_d.src = src_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_lvl = out_q.lvl;
    assign irq_src = out_q.src;
endmodule

// File: rtl/intc_prio_chk.sv
module intc_prio_chk
    import intc_pkg::*;
#(
    parameter int                    NSRC      = 8,
    parameter logic [NSRC*LVL_W-1:0] SRC_LEVEL = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] evt_i,
    input logic [2:0]      cpu_mask,
    input logic [2:0]      irq_lvl,
    input logic [NSRC-1:0] req_w,
    input logic [NSRC-1:0] en_w,
    input logic            master_w
);
    logic [NSRC-1:0] nmi_sel;
    for (genvar g = 0; g < NSRC; g++) begin : g_nmi
        assign nmi_sel[g] = (SRC_LEVEL[g*LVL_W +: LVL_W] == NMI_LVL);
    end

    assert_evt_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((req_w & $past(evt_i)) == $past(evt_i)));

    assert_enabled_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl != 3'd0) |-> ($past(req_w & en_w) != '0));

    assert_above_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl != 3'd0 && irq_lvl != 3'd7) |-> (irq_lvl > $past(cpu_mask)));

    assert_nmi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_w & en_w & nmi_sel) != '0) |=> (irq_lvl == 3'd7));

    assert_master_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(master_w) && irq_lvl != 3'd0) |-> (irq_lvl == 3'd7));
endmodule

bind intc_prio intc_prio_chk #(.NSRC(NSRC), .SRC_LEVEL(SRC_LEVEL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .cpu_mask (cpu_mask),
    .irq_lvl  (irq_lvl),
    .req_w    (req_w),
    .en_w     (en_w),
    .master_w (master_w)
);

// File: tb/intc_prio_bench.sv
module intc_prio_bench;
    localparam int NSRC  = 8;
    localparam int IDX_W = $clog2(NSRC);

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NSRC-1:0]  evt_i;
    logic             bus_wr, bus_sel;
    logic [15:0]      bus_wdata, bus_rdata;
    logic [2:0]       cpu_mask, cpu_ack_lvl, irq_lvl;
    logic             cpu_ack;
    logic [IDX_W-1:0] irq_src;

    always #10 clk = ~clk;

    intc_prio u_intc_prio (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_mask(cpu_mask),
        .cpu_ack(cpu_ack), .cpu_ack_lvl(cpu_ack_lvl), .irq_lvl(irq_lvl), .irq_src(irq_src)
    );

    typedef enum {K_LVL, K_SRC, K_RD} kind_e;
    typedef struct {
        string tag;
        kind_e kind;
        int    exp;
    } item_t;

    item_t sb[$];
    event  sample_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                int    act;
                it = sb.pop_front();
                case (it.kind)
                    K_LVL:   act = int'(irq_lvl);
                    K_SRC:   act = int'(irq_src);
                    default: act = int'(bus_rdata);
                endcase
                checks++;
                if (act != it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%s actual=0x%0h expected=0x%0h",
                             it.tag, it.kind.name(), act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input int i);
        evt_i[i] = 1'b1;
        tick();
        evt_i = '0;
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = data;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic expect_out(input string tag, input int lvl, input int src);
        sb.push_back('{tag, K_LVL, lvl});
        sb.push_back('{tag, K_SRC, src});
        -> sample_ev;
        #1;
    endtask

    task automatic expect_rd(input string tag, input logic sel, input int exp);
        bus_sel = sel;
        #1;
        sb.push_back('{tag, K_RD, exp});
        -> sample_ev;
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; evt_i = '0; bus_wr = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
        cpu_mask = 3'd0; cpu_ack = 1'b0; cpu_ack_lvl = 3'd0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R10: reset state
        expect_out("R10 reset", 0, 0);
        expect_rd("R10 reset pending", 1'b0, 16'h0000);
        expect_rd("R10 reset enable", 1'b1, 16'h0000);

        // R1 latch, R4 disabled stays silent
        pulse(1);
        expect_rd("R1 disk latched", 1'b0, 16'h0002);
        tick();
        expect_out("R4 disabled not signalled", 0, 0);

        // R2 enable set with master
        wr(1'b1, 16'hC0FF);
        expect_rd("R2 enable set", 1'b1, 16'h40FF);
        tick();
        expect_out("R2 disk reported", 1, 1);

        // R8 vblank over disk
        pulse(4);
        tick();
        expect_out("R8 vblank wins", 3, 4);

        // R5 mask comparison
        cpu_mask = 3'd3; tick();
        expect_out("R5 equal mask blocks", 0, 0);
        cpu_mask = 3'd2; tick();
        expect_out("R5 lower mask passes", 3, 4);

        // R2 clear, R9 pending until mask drops
        cpu_mask = 3'd3;
        wr(1'b0, 16'h0010);
        expect_rd("R2 pending clear", 1'b0, 16'h0002);
        tick();
        expect_out("R9 held by mask", 0, 0);
        cpu_mask = 3'd0; tick();
        expect_out("R9 shown after mask drop", 1, 1);

        // R11 lowest index at a shared level
        pulse(0);
        tick();
        expect_out("R11 lowest index", 1, 0);

        // R7 master off
        wr(1'b1, 16'h4000);
        tick();
        expect_out("R7 master off", 0, 0);
        expect_rd("R7 master cleared", 1'b1, 16'h00FF);

        // R6 non-maskable with mask 7 and master off
        cpu_mask = 3'd7;
        pulse(7);
        tick();
        expect_out("R6 level 7 bypasses", 7, 7);

        // R12 acknowledge retires level-7 source
        cpu_ack = 1'b1; cpu_ack_lvl = 3'd7;
        tick();
        cpu_ack = 1'b0;
        expect_rd("R12 ack cleared nmi", 1'b0, 16'h0003);
        tick();
        expect_out("R12 nothing left", 0, 0);
        cpu_mask = 3'd0;

        // R3 event beats software clear
        evt_i[5] = 1'b1;
        wr(1'b0, 16'h0020);
        evt_i = '0;
        expect_rd("R3 event beats clear", 1'b0, 16'h0023);

        wr(1'b1, 16'hC000);
        tick();
        expect_out("R8 level 3 over level 1", 3, 5);

        // R12 ack at level 1 clears lowest index
        cpu_ack = 1'b1; cpu_ack_lvl = 3'd1;
        tick();
        cpu_ack = 1'b0;
        expect_rd("R12 ack lowest index", 1'b0, 16'h0022);
        tick();
        expect_out("R12 winner unchanged", 3, 5);

        // R3 event beats acknowledge
        cpu_ack = 1'b1; cpu_ack_lvl = 3'd3; evt_i[5] = 1'b1;
        tick();
        cpu_ack = 1'b0; evt_i = '0;
        expect_rd("R3 event beats ack", 1'b0, 16'h0022);

        // R4 disable one source, it stays latched
        wr(1'b1, 16'h0020);
        tick();
        expect_out("R4 disabled source skipped", 1, 1);
        expect_rd("R4 still latched", 1'b0, 16'h0022);

        // R10 registered output timing
        pulse(6);
        expect_out("R10 not yet visible", 1, 1);
        tick();
        expect_out("R10 visible next clock", 4, 6);

        // R2 software set
        wr(1'b0, 16'h8008);
        expect_rd("R2 software set", 1'b0, 16'h006A);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule